// File: doc/BRIEF.md
# SPI ADC Command Frame Responder

This block is the digital side of a multichannel sampling converter as a host sees it over SPI. The host sends 16-bit command words. Each word either selects a channel and, if allowed, rewrites a small configuration register, or programs the four general-purpose pins. Conversion values arrive on a parallel sample bus, one 12-bit word per channel. The block latches the selected channel's value when the command frame ends. The reply to that command goes out two frames later, with the channel number in the top nibble.

The SPI pins are oversampled in the system clock domain through two-flop synchronizers. The bus runs in mode 0: the clock idles low, data is sampled on the rising edge and shifted on the falling edge, most significant bit first. A frame spans the time chip select is low. A configuration bit can swap the channel tag of the next reply for the four pin input levels. Another configuration bit powers the block down, which zeroes the replies. The pins drive their programmed levels only where the direction register marks them as outputs.

Top module: `adc_cmd_responder`

## Requirements
- R1: A frame is complete when chip select rises after at least 16 rising SCLK edges; the first 16 MOSI bits, MSB first, form the command. A frame with fewer than 16 rising edges changes no register, output or pipeline stage.
- R2: A command with bit 14 set is a pin-programming command, even if bit 12 is also set. A command with bit 14 clear and bit 12 set is a manual command. Any other complete frame changes no register but still advances the reply pipeline, sampling the last selected channel.
- R3: A manual command loads bits 10:7 as the selected channel. Its bits 6:0 are written into configuration only when bit 11 is 1; otherwise configuration keeps its value. Configuration layout: bits 3:0 pin levels, bit 4 pin-data request, bit 5 power-down (port `pwrdn_out`), bit 6 high range (port `range_hi`).
- R4: The channel selected after frame N is sampled from `sample_data` at the end of frame N. It is shifted out on MISO during frame N+2 as {channel[3:0], sample[11:0]}.
- R5: When configuration bit 4 is 1 after frame N, the reply of frame N+1 carries `gpio_in` sampled at the end of frame N in bits 15:12, with the pipelined sample in bits 11:0.
- R6: When configuration bit 5 is 1 after frame N, the reply of frame N+1 is all zero. Commands are still decoded while it is set, so clearing it resumes normal replies.
- R7: A pin-programming command without bit 9 loads bits 3:0 as pin direction (1 = output). `gpio_oe` equals the direction, and `gpio_out` carries the level bits on output pins and 0 on input pins.
- R8: A pin-programming command with bit 9 set restores the configuration to its reset value, clears direction and selects channel 0; its bits 3:0 are ignored.
- R9: After reset, configuration is 7'b1000000 (high range on, power-down off), all pins are inputs, MISO is 0, and the first two replies are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also used to oversample the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI chip select, active low, delimits a frame |
| spi_mosi | input | 1 | Command data from the host |
| spi_miso | output | 1 | Reply data to the host, 0 while deselected |
| sample_data | input | NUM_CH*12 | Conversion values, channel k in bits k*12 +: 12 |
| gpio_in | input | 4 | Pin input levels |
| gpio_out | output | 4 | Pin output levels, zero on input pins |
| gpio_oe | output | 4 | Pin output enables, 1 = driven |
| range_hi | output | 1 | High input range select to the analog front end |
| pwrdn_out | output | 1 | Power-down request to the analog front end |

## Verification
The hardest situation to reach from the ports is the one where the pipeline, the write gate and the reply substitutions act at once. An example is a frame that sets the pin-data or power-down bit while the value sampled two frames earlier is still waiting to go out. A truncated frame that must leave all of this untouched is a second such case. The bench reaches these with directed sequences that stack such frames back to back. It also runs a seeded random mix of all command classes, with fresh sample and pin values every frame, against a frame-level reference model.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;
    localparam int FRAME_W = 16;
    localparam int TAG_W   = 4;
    localparam int SMP_W   = FRAME_W - TAG_W;
    localparam int NGPIO   = 4;

    // command bit positions (fixed by the host protocol)
    localparam int B_PINCMD = 14;
    localparam int B_MANUAL = 12;
    localparam int B_WREN   = 11;
    localparam int B_RSTALL = 9;
    localparam int CH_LSB   = 7;

    // packed so that it maps one-to-one onto command bits 6:0
    typedef struct packed {
        logic             range_hi;
        logic             pwrdn;
        logic             pin_rd;
        logic [NGPIO-1:0] pin_lvl;
    } cfg_t;

    localparam int   CFG_W   = $bits(cfg_t);
    localparam cfg_t CFG_RST = cfg_t'(7'b1000000);
endpackage

// File: rtl/adc_spi_frame.sv
module adc_spi_frame
    import adc_resp_pkg::*;
#(
    parameter int W = FRAME_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk,
    input  logic         cs_n,
    input  logic         mosi,
    input  logic [W-1:0] tx_word,
    output logic         miso,
    output logic         cs_active,
    output logic         frame_valid,
    output logic [W-1:0] frame_word
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [1:0]       sclk_s;
        logic [1:0]       cs_s;
        logic [1:0]       mosi_s;
        logic             sclk_p;
        logic             cs_p;
        logic [W-1:0]     rx;
        logic [W-1:0]     tx;
        logic [CNT_W-1:0] cnt;
        logic             valid;
    } spi_st_t;

    spi_st_t st_d, st_q;

    always_comb begin
        logic sclk_now, cs_now, mosi_now;
        st_d        = st_q;
        st_d.sclk_s = {st_q.sclk_s[0], sclk};
        st_d.cs_s   = {st_q.cs_s[0], cs_n};
        st_d.mosi_s = {st_q.mosi_s[0], mosi};
        sclk_now    = st_q.sclk_s[1];
        cs_now      = st_q.cs_s[1];
        mosi_now    = st_q.mosi_s[1];
        st_d.sclk_p = sclk_now;
        st_d.cs_p   = cs_now;
        st_d.valid  = 1'b0;
        if (st_q.cs_p && !cs_now) begin
            st_d.tx  = tx_word;
            st_d.rx  = '0;
            st_d.cnt = '0;
        end else if (!cs_now) begin
            if (sclk_now && !st_q.sclk_p && st_q.cnt < CNT_W'(W)) begin
                st_d.rx  = {st_q.rx[W-2:0], mosi_now};
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (!sclk_now && st_q.sclk_p) begin
                st_d.tx = {st_q.tx[W-2:0], 1'b0};
            end
        end else if (!st_q.cs_p && st_q.cnt == CNT_W'(W)) begin
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.cs_s   <= 2'b11;
            st_q.cs_p   <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cs_active   = !st_q.cs_s[1];
    assign miso        = cs_active & st_q.tx[W-1];
    assign frame_valid = st_q.valid;
    assign frame_word  = st_q.rx;
endmodule

// File: rtl/adc_cmd_regs.sv
module adc_cmd_regs
    import adc_resp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_valid,
    input  logic [FRAME_W-1:0] frame_word,
    output cfg_t               cfg,
    output logic [NGPIO-1:0]   dir,
    output logic [TAG_W-1:0]   ch,
    output logic               adv
);
    typedef struct packed {
        cfg_t             cfg;
        logic [NGPIO-1:0] dir;
        logic [TAG_W-1:0] ch;
        logic             adv;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    unused_bits;

    assign unused_bits = ^{frame_word[15], frame_word[13]};

    always_comb begin
        st_d     = st_q;
        st_d.adv = frame_valid;
        if (frame_valid) begin
            if (frame_word[B_PINCMD]) begin
                if (frame_word[B_RSTALL]) begin
                    st_d.cfg = CFG_RST;
                    st_d.dir = '0;
                    st_d.ch  = '0;
                end else begin
                    st_d.dir = frame_word[NGPIO-1:0];
                end
            end else if (frame_word[B_MANUAL]) begin
                st_d.ch = frame_word[CH_LSB +: TAG_W];
                if (frame_word[B_WREN]) begin
                    st_d.cfg = cfg_t'(frame_word[CFG_W-1:0]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg = st_q.cfg;
    assign dir = st_q.dir;
    assign ch  = st_q.ch;
    assign adv = st_q.adv;
endmodule

// File: rtl/adc_reply_pipe.sv
module adc_reply_pipe
    import adc_resp_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    input  logic [TAG_W-1:0]        ch,
    input  logic                    pwrdn,
    input  logic                    pin_rd,
    input  logic [NGPIO-1:0]        gpio_in,
    input  logic [NUM_CH*SMP_W-1:0] sample_data,
    output logic [FRAME_W-1:0]      reply
);
    typedef struct packed {
        logic [TAG_W-1:0]   conv_ch;
        logic [SMP_W-1:0]   conv_smp;
        logic [FRAME_W-1:0] rep;
    } pipe_st_t;

    pipe_st_t         st_d, st_q;
    logic [SMP_W-1:0] smp [NUM_CH];
    logic [SMP_W-1:0] sel;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_unpack
        assign smp[k] = sample_data[k*SMP_W +: SMP_W];
    end

    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (int'(ch) == k) sel = smp[k];
        end
    end

    always_comb begin
        st_d = st_q;
        if (adv) begin
            if (pwrdn) begin
                st_d.rep = '0;
            end else begin
                st_d.rep = {(pin_rd ? gpio_in : st_q.conv_ch), st_q.conv_smp};
            end
            st_d.conv_ch  = ch;
            st_d.conv_smp = sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reply = st_q.rep;
endmodule

// File: rtl/adc_cmd_responder.sv
module adc_cmd_responder
    import adc_resp_pkg::*;
#(
    parameter int NUM_CH = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sclk,
    input  logic                    spi_cs_n,
    input  logic                    spi_mosi,
    output logic                    spi_miso,
    input  logic [NUM_CH*SMP_W-1:0] sample_data,
    input  logic [NGPIO-1:0]        gpio_in,
    output logic [NGPIO-1:0]        gpio_out,
    output logic [NGPIO-1:0]        gpio_oe,
    output logic                    range_hi,
    output logic                    pwrdn_out
);
    logic               frame_valid;
    logic [FRAME_W-1:0] frame_word;
    logic               cs_active;
    logic [FRAME_W-1:0] reply;
    cfg_t               cfg;
    logic [NGPIO-1:0]   dir;
    logic [TAG_W-1:0]   ch;
    logic               adv;

    adc_spi_frame #(.W(FRAME_W)) u_spi (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk        (spi_sclk),
        .cs_n        (spi_cs_n),
        .mosi        (spi_mosi),
        .tx_word     (reply),
        .miso        (spi_miso),
        .cs_active   (cs_active),
        .frame_valid (frame_valid),
        .frame_word  (frame_word)
    );

    adc_cmd_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (frame_valid),
        .frame_word  (frame_word),
        .cfg         (cfg),
        .dir         (dir),
        .ch          (ch),
        .adv         (adv)
    );

    adc_reply_pipe #(.NUM_CH(NUM_CH)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .adv         (adv),
        .ch          (ch),
        .pwrdn       (cfg.pwrdn),
        .pin_rd      (cfg.pin_rd),
        .gpio_in     (gpio_in),
        .sample_data (sample_data),
        .reply       (reply)
    );

    assign gpio_oe   = dir;
    assign gpio_out  = cfg.pin_lvl & dir;
    assign range_hi  = cfg.range_hi;
    assign pwrdn_out = cfg.pwrdn;
endmodule

// File: rtl/adc_cmd_responder_chk.sv
module adc_cmd_responder_chk
    import adc_resp_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               frame_valid,
    input logic [FRAME_W-1:0] frame_word,
    input logic               adv,
    input logic               cs_active,
    input cfg_t               cfg,
    input logic [NGPIO-1:0]   dir,
    input logic [FRAME_W-1:0] reply,
    input logic [NGPIO-1:0]   gpio_oe
);
    // R7
    oe_moves_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpio_oe) |-> $past(frame_valid));

    // R3
    cfg_held_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && !frame_word[B_PINCMD] && frame_word[B_MANUAL] && !frame_word[B_WREN])
        |=> $stable(cfg));

    // R6
    pwrdn_zero_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && cfg.pwrdn) |=> (reply == '0));

    // R4
    reply_frozen_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_active && $past(cs_active)) |-> $stable(reply));

    // R8
    reset_cmd_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_valid && frame_word[B_PINCMD] && frame_word[B_RSTALL])
        |=> (cfg == CFG_RST && dir == '0));
endmodule

bind adc_cmd_responder adc_cmd_responder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_valid (frame_valid),
    .frame_word  (frame_word),
    .adv         (adv),
    .cs_active   (cs_active),
    .cfg         (cfg),
    .dir         (dir),
    .reply       (reply),
    .gpio_oe     (gpio_oe)
);

// File: tb/adc_cmd_responder_tb.sv
module adc_cmd_responder_tb;
    localparam int NUM_CH = 16;
    localparam int H      = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst_n;
    logic                 sclk, cs_n, mosi, miso;
    logic [NUM_CH*12-1:0] sample_data;
    logic [3:0]           gpio_in, gpio_out, gpio_oe;
    logic                 range_hi, pwrdn_out;

    logic [11:0] smp [NUM_CH];
    for (genvar k = 0; k < NUM_CH; k++) begin : g_pack
        assign sample_data[k*12 +: 12] = smp[k];
    end

    adc_cmd_responder #(.NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n),
        .spi_mosi(mosi), .spi_miso(miso), .sample_data(sample_data),
        .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .range_hi(range_hi), .pwrdn_out(pwrdn_out)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [6:0]  m_cfg;
    logic [3:0]  m_dir, m_ch, m_cch;
    logic [11:0] m_cs;
    logic [15:0] m_rep;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic shuffle();
        for (int k = 0; k < NUM_CH; k++) smp[k] = 12'($urandom);
        gpio_in = 4'($urandom);
    endtask

    task automatic xfer(input logic [15:0] w, input int nb, output logic [15:0] rx);
        rx = '0;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            mosi = w[15-i];
            repeat (H) @(negedge clk);
            rx[15-i] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (3*H) @(negedge clk);
    endtask

    task automatic model_frame(input logic [15:0] w);
        logic [15:0] nrep;
        if (w[14]) begin
            if (w[9]) begin
                m_cfg = 7'h40; m_dir = '0; m_ch = '0;
            end else begin
                m_dir = w[3:0];
            end
        end else if (w[12]) begin
            m_ch = w[10:7];
            if (w[11]) m_cfg = w[6:0];
        end
        nrep  = m_cfg[5] ? 16'h0 : {(m_cfg[4] ? gpio_in : m_cch), m_cs};
        m_cch = m_ch;
        m_cs  = smp[m_ch];
        m_rep = nrep;
    endtask

    task automatic check_outs(input string req);
        check({req, " R7 gpio_oe"}, 32'(gpio_oe), 32'(m_dir));
        check({req, " R7 gpio_out"}, 32'(gpio_out), 32'(m_cfg[3:0] & m_dir));
        check({req, " R3 range_hi"}, 32'(range_hi), 32'(m_cfg[6]));
        check({req, " R3 pwrdn_out"}, 32'(pwrdn_out), 32'(m_cfg[5]));
    endtask

    task automatic frame(input logic [15:0] w, input string req);
        logic [15:0] rx;
        xfer(w, 16, rx);
        check({req, " reply"}, 32'(rx), 32'(m_rep));
        model_frame(w);
        check_outs(req);
        shuffle();
    endtask

    function automatic logic [15:0] man(input logic [3:0] c, input logic wr, input logic [6:0] lo);
        return {3'b000, 1'b1, wr, c, lo};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [15:0] rx;
        void'($urandom(32'd4242));
        rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
        shuffle();
        m_cfg = 7'h40; m_dir = '0; m_ch = '0; m_cch = '0; m_cs = '0; m_rep = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9 reset state
        check("R9 miso", 32'(miso), 0);
        check("R9 gpio_oe", 32'(gpio_oe), 0);
        check("R9 range_hi", 32'(range_hi), 1);
        check("R9 pwrdn_out", 32'(pwrdn_out), 0);

        // R4 two-frame latency, first replies zero (R9)
        frame(man(4'd3, 1'b0, 7'h00), "R9");
        frame(man(4'd5, 1'b0, 7'h00), "R9");
        frame(man(4'd9, 1'b0, 7'h00), "R4");
        frame(man(4'd15, 1'b0, 7'h00), "R4");
        // R3 write enabled: levels 1010, low range
        frame(man(4'd0, 1'b1, 7'b0001010), "R3");
        // R7 all pins output
        frame(16'h400F, "R7");
        // R3 no write: low bits ignored
        frame(man(4'd1, 1'b0, 7'h7F), "R3");
        // R2 both class bits: pin command wins
        frame(16'h5000 | 16'h0005, "R2");
        // R5 pin-data request, then clear
        frame(man(4'd2, 1'b1, 7'b0010110), "R5");
        frame(man(4'd4, 1'b0, 7'h00), "R5");
        frame(man(4'd6, 1'b1, 7'b0000110), "R5");
        // R6 power-down keeps decoding, then wake
        frame(man(4'd7, 1'b1, 7'b0100011), "R6");
        frame(man(4'd8, 1'b0, 7'h00), "R6");
        frame(16'h400C, "R6");
        frame(man(4'd10, 1'b1, 7'b1000011), "R6");
        frame(man(4'd11, 1'b0, 7'h00), "R6");
        // R1 short frame: no effect on pins or pipeline
        xfer(16'h4000, 10, rx);
        check_outs("R1 short");
        frame(man(4'd12, 1'b0, 7'h00), "R1");
        xfer(man(4'd13, 1'b1, 7'b0100000), 15, rx);
        check_outs("R1 short15");
        frame(man(4'd14, 1'b0, 7'h00), "R1");
        // R2 idle frame advances pipeline with held channel
        frame(16'h0000, "R2");
        frame(16'h2FFF, "R2");
        // R8 reset command ignores direction bits
        frame(16'h420F, "R8");
        frame(man(4'd3, 1'b0, 7'h00), "R8");

        // seeded random mix
        for (int n = 0; n < 40; n++) begin
            logic [15:0] w;
            int cls;
            w   = 16'($urandom);
            cls = int'($urandom % 8);
            if (cls < 4)       w = man(4'($urandom), 1'($urandom), 7'($urandom) & 7'h5F);
            else if (cls == 4) w = {2'b01, w[13:10], 1'b0, w[8:0]};
            else if (cls == 5) w = man(4'($urandom), 1'b1, 7'($urandom));
            else if (cls == 6) w = w & 16'hAFFF;
            frame(w, "R4");
        end

        summary();
        $finish;
    end
endmodule